// File: doc/BRIEF.md
# Interrupt Moderation Controller for a Network Interface

This block gathers interrupt causes from the receive and transmit halves of a network controller and decides when the single interrupt line to the host CPU goes high. A pending-cause register latches every posted cause. A mask register selects the causes that may drive the line. A throttle counter keeps a minimum gap between two interrupt assertions, and a post marked as immediate may bypass that gap.

Each direction has a pair of delay timers. The per-packet timer restarts on every packet. The absolute timer starts on the first packet of a burst and runs to the end. When either timer of a pair expires, the pair sends its descriptor engine a one-cycle writeback request with no alignment restriction. On the following cycle it posts its cause: the receive-timer cause for the receive pair, and the transmit-descriptor-written cause for the transmit pair. A completed transmit descriptor writeback also posts the transmit cause. All timer and throttle values count pulses of `time_tick`, which occurs once every 1024 ns.

Top module: `nic_irq_moderator`

## Requirements
- R1: After reset, `irq`, `rx_wb_req` and `tx_wb_req` are 0. The pending register reads 0, the mask is 0 (all causes disabled), and every timer value is 0.
- R2: A pulse on bit i of `cause_post` sets pending bit i on the next clock edge. Bit 0 is the transmit-descriptor-written cause and bit 1 is the receive-timer cause. If the bit is unmasked and the throttle count is zero, `irq` rises on that same edge.
- R3: A mask bit of 1 enables its cause. A write to the mask re-evaluates the pending causes at once: enabling a pending cause raises `irq`, and disabling every pending cause drops `irq`. `irq` is never high without a pending, unmasked cause.
- R4: When `cause_rd` is high, `cause_rdata` shows the pending register, and the register clears on that edge. A cause posted in the same cycle survives the clear. `irq` falls when no unmasked cause remains. A pending bit is never cleared except by a read.
- R5: Each rise of `irq` loads the throttle count from the throttle value. The count drops by one on each tick. A non-immediate cause raises `irq` only when the count is zero, so a cause blocked by the throttle raises `irq` on the edge after the count reaches zero.
- R6: A `cause_post` with `cause_now` high raises `irq` on the next edge whatever the throttle count.
- R7: `tmr_sel` selects which value a timer write loads: 0 receive packet delay, 1 receive absolute delay, 2 transmit packet delay, 3 transmit absolute delay, 4 throttle. A delay value of 0 disables that timer.
- R8: A packet starts its packet timer from the loaded value, and each further packet restarts it. The timer expires on the tick that ends the interval. Expiry gives a one-cycle writeback request, and the cause is posted to the pending register on the next cycle.
- R9: The absolute timer starts on the first packet while it is idle. Later packets do not restart it, and it expires that many ticks after the first packet.
- R10: Expiry of either timer in a pair stops both timers of that pair.
- R11: The transmit pair uses `tx_pkt` and `tx_wb_req` and posts cause bit 0. A pulse on `tx_wb_done` also posts cause bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_tick | input | 1 | One-cycle pulse every 1024 ns |
| cause_post | input | NUM_CAUSES | Cause post strobes, one bit per cause |
| cause_now | input | 1 | Posts in this cycle bypass the throttle |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | NUM_CAUSES | New mask value, 1 = enabled |
| cause_rd | input | 1 | Read-and-clear of the pending register |
| cause_rdata | output | NUM_CAUSES | Pending register contents |
| tmr_wr | input | 1 | Timer value write strobe |
| tmr_sel | input | 3 | Timer value select |
| tmr_wdata | input | TMR_W | Timer value in ticks |
| rx_pkt | input | 1 | Receive packet event |
| tx_pkt | input | 1 | Transmit packet event |
| tx_wb_done | input | 1 | Transmit descriptor writeback finished |
| rx_wb_req | output | 1 | Receive descriptor writeback request pulse |
| tx_wb_req | output | 1 | Transmit descriptor writeback request pulse |
| irq | output | 1 | Interrupt line to the CPU |

## Verification
A stale throttle count shows at the ports as an `irq` rise that is missing or one tick early, on the first cause posted after a previous interrupt. A wrongly restarted or uncancelled delay counter shows as a writeback pulse in the wrong tick, or a second pulse later. The bench counts ticks between each packet and each pulse, so such a fault shows within a few ticks. A pending or mask bit that is lost or stuck shows on the next read or the next mask write, through `cause_rdata` or `irq`.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
    localparam int CAUSE_TXDW = 0;
    localparam int CAUSE_RXT  = 1;
    localparam int NUM_TMR    = 5;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_RX_PKT   = 3'd0,
        SEL_RX_ABS   = 3'd1,
        SEL_TX_PKT   = 3'd2,
        SEL_TX_ABS   = 3'd3,
        SEL_THROTTLE = 3'd4
    } tmr_sel_e;
endpackage

// File: rtl/irqmod_delay_pair.sv
module irqmod_delay_pair #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pkt,
    input  logic [TW-1:0] pkt_dly,
    input  logic [TW-1:0] abs_dly,
    output logic          wb_req,
    output logic          post
);
    typedef struct packed {
        logic [TW-1:0] pkt_cnt;
        logic [TW-1:0] abs_cnt;
        logic          pkt_run;
        logic          abs_run;
        logic          wb;
        logic          post;
    } st_t;

    st_t st_q, st_d;
    logic pkt_exp, abs_exp;

    always_comb begin
        st_d      = st_q;
        st_d.wb   = 1'b0;
        st_d.post = st_q.wb;
        pkt_exp   = st_q.pkt_run && tick && (st_q.pkt_cnt == TW'(1));
        abs_exp   = st_q.abs_run && tick && (st_q.abs_cnt == TW'(1));
        if (tick && st_q.pkt_run) st_d.pkt_cnt = st_q.pkt_cnt - 1'b1;
        if (tick && st_q.abs_run) st_d.abs_cnt = st_q.abs_cnt - 1'b1;
        if (pkt_exp || abs_exp) begin
            st_d.wb      = 1'b1;
            st_d.pkt_run = 1'b0;
            st_d.abs_run = 1'b0;
            st_d.pkt_cnt = '0;
            st_d.abs_cnt = '0;
        end
        if (pkt) begin
            if (pkt_dly != '0) begin
                st_d.pkt_run = 1'b1;
                st_d.pkt_cnt = pkt_dly;
            end
            if (!st_d.abs_run && abs_dly != '0) begin
                st_d.abs_run = 1'b1;
                st_d.abs_cnt = abs_dly;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_req = st_q.wb;
    assign post   = st_q.post;

    // R8: a running packet counter never sits at zero
    p_cnt_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pkt_run |-> st_q.pkt_cnt != '0);

    // R9: a running absolute counter only counts down until it expires
    p_abs_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.abs_run) && st_q.abs_run && !st_q.wb)
            |-> st_q.abs_cnt <= $past(st_q.abs_cnt));
endmodule

// File: rtl/irqmod_cause_core.sv
module irqmod_cause_core #(
    parameter int NC = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [NC-1:0] ext_post,
    input  logic          ext_now,
    input  logic [NC-1:0] int_post,
    input  logic          mask_wr,
    input  logic [NC-1:0] mask_wdata,
    input  logic          cause_rd,
    input  logic [TW-1:0] thr_val,
    output logic [NC-1:0] pending,
    output logic          irq
);
    typedef struct packed {
        logic [NC-1:0] pend;
        logic [NC-1:0] mask;
        logic [TW-1:0] thr;
        logic          irq;
    } st_t;

    st_t st_q, st_d;
    logic imm_hit;
    logic active;

    always_comb begin
        st_d      = st_q;
        imm_hit   = ext_now && (ext_post != '0);
        st_d.pend = (cause_rd ? '0 : st_q.pend) | ext_post | int_post;
        if (mask_wr) st_d.mask = mask_wdata;
        if (tick && st_q.thr != '0) st_d.thr = st_q.thr - 1'b1;
        active = (st_d.pend & st_d.mask) != '0;
        if (!active) begin
            st_d.irq = 1'b0;
        end else if (!st_q.irq && (st_q.thr == '0 || imm_hit)) begin
            st_d.irq = 1'b1;
            st_d.thr = thr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;
    assign irq     = st_q.irq;

    // R3: the line needs a pending, unmasked cause
    p_irq_needs_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.pend & st_q.mask) != '0);

    // R5: a rise happens only with an idle throttle or an immediate post
    p_throttle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> ($past(st_q.thr) == '0 || $past(imm_hit)));

    // R5: every rise reloads the throttle count
    p_throttle_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> st_q.thr == $past(thr_val));

    // R4: pending bits clear only through a read
    p_pending_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cause_rd) |-> (st_q.pend & $past(st_q.pend)) == $past(st_q.pend));
endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator
    import irqmod_pkg::*;
#(
    parameter int NUM_CAUSES = 8,
    parameter int TMR_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  time_tick,
    input  logic [NUM_CAUSES-1:0] cause_post,
    input  logic                  cause_now,
    input  logic                  mask_wr,
    input  logic [NUM_CAUSES-1:0] mask_wdata,
    input  logic                  cause_rd,
    output logic [NUM_CAUSES-1:0] cause_rdata,
    input  logic                  tmr_wr,
    input  logic [SEL_W-1:0]      tmr_sel,
    input  logic [TMR_W-1:0]      tmr_wdata,
    input  logic                  rx_pkt,
    input  logic                  tx_pkt,
    input  logic                  tx_wb_done,
    output logic                  rx_wb_req,
    output logic                  tx_wb_req,
    output logic                  irq
);
    localparam int NUM_PAIRS = 2;

    logic [TMR_W-1:0] dly_q [NUM_TMR];
    logic [TMR_W-1:0] dly_d [NUM_TMR];

    always_comb begin
        for (int i = 0; i < NUM_TMR; i++) dly_d[i] = dly_q[i];
        if (tmr_wr && 32'(tmr_sel) < NUM_TMR) dly_d[tmr_sel] = tmr_wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_TMR; i++) begin
            if (!rst_n) dly_q[i] <= '0;
            else        dly_q[i] <= dly_d[i];
        end
    end

    logic [NUM_PAIRS-1:0] pair_pkt, pair_wb, pair_post;
    assign pair_pkt = {tx_pkt, rx_pkt};

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        irqmod_delay_pair #(.TW(TMR_W)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (time_tick),
            .pkt     (pair_pkt[g]),
            .pkt_dly (dly_q[2*g]),
            .abs_dly (dly_q[2*g+1]),
            .wb_req  (pair_wb[g]),
            .post    (pair_post[g])
        );
    end

    logic [NUM_CAUSES-1:0] int_post;
    always_comb begin
        int_post             = '0;
        int_post[CAUSE_RXT]  = pair_post[0];
        int_post[CAUSE_TXDW] = pair_post[1] | tx_wb_done;
    end

    irqmod_cause_core #(.NC(NUM_CAUSES), .TW(TMR_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (time_tick),
        .ext_post   (cause_post),
        .ext_now    (cause_now),
        .int_post   (int_post),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .cause_rd   (cause_rd),
        .thr_val    (dly_q[SEL_THROTTLE]),
        .pending    (cause_rdata),
        .irq        (irq)
    );

    assign rx_wb_req = pair_wb[0];
    assign tx_wb_req = pair_wb[1];
endmodule

// File: tb/tb_nic_irq_moderator.sv
module tb_nic_irq_moderator;
    localparam int NC = 8;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic time_tick = 1'b0;
    logic [NC-1:0] cause_post = '0;
    logic cause_now = 1'b0;
    logic mask_wr = 1'b0;
    logic [NC-1:0] mask_wdata = '0;
    logic cause_rd = 1'b0;
    logic [NC-1:0] cause_rdata;
    logic tmr_wr = 1'b0;
    logic [2:0] tmr_sel = '0;
    logic [TW-1:0] tmr_wdata = '0;
    logic rx_pkt = 1'b0, tx_pkt = 1'b0, tx_wb_done = 1'b0;
    logic rx_wb_req, tx_wb_req, irq;

    int n_checks = 0;
    int n_fail = 0;
    int rx_seen = 0;
    int tx_seen = 0;
    byte exp_q[$];
    bit done = 0;

    always #10 clk = ~clk;

    nic_irq_moderator #(.NUM_CAUSES(NC), .TMR_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .time_tick(time_tick),
        .cause_post(cause_post), .cause_now(cause_now),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .cause_rd(cause_rd), .cause_rdata(cause_rdata),
        .tmr_wr(tmr_wr), .tmr_sel(tmr_sel), .tmr_wdata(tmr_wdata),
        .rx_pkt(rx_pkt), .tx_pkt(tx_pkt), .tx_wb_done(tx_wb_done),
        .rx_wb_req(rx_wb_req), .tx_wb_req(tx_wb_req), .irq(irq)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: each writeback pulse must match the next expected item
    task automatic sb_pop(byte kind);
        n_checks++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R8: actual unexpected pulse %c expected none", kind);
        end else begin
            byte e = exp_q.pop_front();
            if (e != kind) begin
                n_fail++;
                $display("FAIL R11: actual pulse %c expected %c", kind, e);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_wb_req) begin rx_seen++; sb_pop("R"); end
            if (tx_wb_req) begin tx_seen++; sb_pop("T"); end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(negedge clk) time_tick = 1'b1;
            @(negedge clk) time_tick = 1'b0;
        end
    endtask

    task automatic post(logic [NC-1:0] v, logic now);
        @(negedge clk) begin cause_post = v; cause_now = now; end
        @(negedge clk) begin cause_post = '0; cause_now = 1'b0; end
    endtask

    task automatic set_mask(logic [NC-1:0] v);
        @(negedge clk) begin mask_wr = 1'b1; mask_wdata = v; end
        @(negedge clk) mask_wr = 1'b0;
    endtask

    task automatic set_tmr(int sel, int v);
        @(negedge clk) begin tmr_wr = 1'b1; tmr_sel = 3'(sel); tmr_wdata = TW'(v); end
        @(negedge clk) tmr_wr = 1'b0;
    endtask

    task automatic read_pend(output int v, input logic [NC-1:0] also_post);
        @(negedge clk) begin cause_rd = 1'b1; cause_post = also_post; end
        #1 v = int'(cause_rdata);
        @(negedge clk) begin cause_rd = 1'b0; cause_post = '0; end
    endtask

    task automatic pulse_rx();
        @(negedge clk) rx_pkt = 1'b1;
        @(negedge clk) rx_pkt = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk) tx_pkt = 1'b1;
        @(negedge clk) tx_pkt = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int base;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 irq", int'(irq), 0);
        check("R1 pending", int'(cause_rdata), 0);
        check("R1 wb", int'(rx_wb_req | tx_wb_req), 0);

        // R3 masked cause stays silent, mask write raises and drops
        post(8'h04, 1'b0);
        check("R3 masked pending", int'(cause_rdata), 4);
        check("R3 masked irq", int'(irq), 0);
        set_mask(8'h04);
        check("R3 mask raise", int'(irq), 1);
        set_mask(8'h00);
        check("R3 mask drop", int'(irq), 0);

        // R4 read-clear
        read_pend(v, '0);
        check("R4 read value", v, 4);
        check("R4 cleared", int'(cause_rdata), 0);

        // R2 post with unmasked cause raises line next edge
        set_mask(8'h0F);
        post(8'h04, 1'b0);
        check("R2 pending bit", int'(cause_rdata), 4);
        check("R2 irq", int'(irq), 1);
        read_pend(v, 8'h08);
        check("R4 read returns", v, 4);
        check("R4 same-cycle post survives", int'(cause_rdata), 8);
        read_pend(v, '0);
        check("R4 irq drops", int'(irq), 0);

        // R5 throttle
        set_tmr(4, 3);
        post(8'h04, 1'b0);
        check("R5 first irq", int'(irq), 1);
        read_pend(v, '0);
        check("R5 irq dropped", int'(irq), 0);
        post(8'h04, 1'b0);
        check("R5 blocked", int'(irq), 0);
        ticks(2);
        check("R5 still blocked", int'(irq), 0);
        ticks(1);
        check("R5 count just zero", int'(irq), 0);
        step(1);
        check("R5 raised after zero", int'(irq), 1);

        // R6 immediate bypass
        read_pend(v, '0);
        check("R6 cleared", int'(irq), 0);
        post(8'h04, 1'b1);
        check("R6 immediate", int'(irq), 1);
        read_pend(v, '0);
        set_tmr(4, 0);

        // R7 zero value disables timers
        base = rx_seen;
        pulse_rx();
        ticks(10);
        check("R7 disabled timer", rx_seen - base, 0);

        // R8 packet timer restart
        set_tmr(0, 4);
        base = rx_seen;
        pulse_rx();
        ticks(2);
        pulse_rx();
        ticks(3);
        check("R8 restarted no pulse", rx_seen - base, 0);
        exp_q.push_back("R");
        ticks(1);
        check("R8 wb pulse", int'(rx_wb_req), 1);
        step(1);
        check("R8 pulse one cycle", int'(rx_wb_req), 0);
        check("R8 not yet posted", int'(cause_rdata), 0);
        step(1);
        check("R8 rx cause posted", int'(cause_rdata), 2);
        read_pend(v, '0);

        // R9 absolute timer not restarted
        set_tmr(0, 5);
        set_tmr(1, 4);
        base = rx_seen;
        exp_q.push_back("R");
        pulse_rx(); ticks(1);
        pulse_rx(); ticks(1);
        pulse_rx(); ticks(1);
        pulse_rx();
        check("R9 before expiry", rx_seen - base, 0);
        ticks(1);
        check("R9 abs expiry", int'(rx_wb_req), 1);
        // R10 pair stops after expiry
        ticks(8);
        check("R10 no second pulse", rx_seen - base, 1);
        read_pend(v, '0);
        check("R9 rx cause", v & 2, 2);

        // R11 transmit pair and writeback done
        set_tmr(2, 2);
        base = tx_seen;
        exp_q.push_back("T");
        pulse_tx();
        ticks(2);
        check("R11 tx wb pulse", int'(tx_wb_req), 1);
        step(2);
        check("R11 tx cause", int'(cause_rdata), 1);
        read_pend(v, '0);
        @(negedge clk) tx_wb_done = 1'b1;
        @(negedge clk) tx_wb_done = 1'b0;
        check("R11 wb done cause", int'(cause_rdata), 1);
        check("R11 tx pulses", tx_seen - base, 1);
        check("R8 scoreboard drained", exp_q.size(), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule